// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives a 64-word by 16-bit serial EEPROM over a three-wire link: a chip select, a serial clock and a data line toward the device, plus one data line back from it. A client gives a command through a parallel request port using a valid/ready handshake. The port carries a 3-bit command code, a 6-bit word address and a 16-bit data word. The controller builds the serial frame. It clocks the frame out using a serial clock made by a parameterised divider, and it finishes the transaction with a one-cycle completion pulse.

A read returns the addressed word on the completion cycle. The device puts a zero dummy bit ahead of the word, and the controller drops that bit. A programming command (single-word write, single-word erase, erase of the whole array, write of the whole array) starts a self-timed operation inside the device. After such a command the controller holds chip select low for a programmable number of system clocks. It then raises chip select and samples the device's data line once per divider period until the line reads 1, which means ready. If ready does not appear within a parameterised number of samples, the transaction completes with an error flag.

The enable and disable commands switch the device's write protection. These commands finish as soon as their frame has been sent. The device starts up write-protected, so a client must send an enable command before any programming command can take effect.

Top module: `sereep_host`

## Requirements
- R1: Each frame is sent most significant bit first and has this layout: a start bit of 1, a 2-bit opcode, then a 6-bit address field. req_cmd selects the frame as follows:
  - 0 = read, opcode 10, the request address.
  - 1 = write, opcode 01, the request address, followed by 16 data bits.
  - 2 = erase, opcode 11, the request address.
  - 3 = enable, opcode 00, address 110000.
  - 4 = disable, opcode 00, address 000000.
  - 5 = erase-all, opcode 00, address 100000.
  - 6 = write-all, opcode 00, address 010000, followed by 16 data bits.
  - 7 is sent as the disable command.
- R2: The serial clock has a period of 2*SK_HALF system clocks and a rising edge for each bit. ee_di changes only while ee_sk is low, and ee_cs stays high for the whole frame.
- R3: A read makes 17 rising edges after the frame. The controller samples ee_do just before each of these edges, drops the first sample (the dummy bit) and returns the other 16 samples on rd_data, most significant bit first, in the done cycle.
- R4: After a programming command (write, erase, erase-all, write-all), ee_cs stays low for GAP_CYC system clocks and then goes high again. The transaction completes when an ee_do sample reads 1.
- R5: If MAX_POLLS consecutive ee_do samples all read 0, the transaction completes with err high in the done cycle. err is never high outside a done cycle.
- R6: The enable and disable commands raise ee_cs once only, and they complete right after their frame without polling.
- R7: req_ready is high only while idle, and a request is taken when req_valid and req_ready are both high. done is high for exactly one cycle per request. At completion ee_cs is low.
- R8: After reset, ee_cs, ee_sk, ee_di, done and err are 0 and req_ready is 1.
- R9: While ee_cs is low, ee_sk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_cmd | input | 3 | Command code (see R1) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for write and write-all |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, valid only with done |
| err | output | 1 | Ready-poll timeout, valid only with done |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data and ready/busy from the device |

## Verification
The assertions assume three things about the inputs:
- ee_do changes only after a rising edge of ee_sk or while the device is busy, so the value sampled at each rising edge was settled for at least half a serial period.
- The request fields are sampled only at the cycle in which the request is taken.
- The device answers a programming frame by reading 0 while busy and 1 once ready.

The bench's device model meets these assumptions by updating its output on the falling system-clock edge that follows a rising edge of ee_sk. The stimulus drives request fields at falling system-clock edges and drops req_valid one cycle after raising it. Ready/busy timing comes from a fixed busy count that is shorter than the poll timeout, except when the model is deliberately held busy for the timeout case.

// File: rtl/sereep_pkg.sv
`timescale 1ns/1ps
package sereep_pkg;
   typedef enum logic [2:0] {
      CMD_READ  = 3'd0,
      CMD_WRITE = 3'd1,
      CMD_ERASE = 3'd2,
      CMD_EWEN  = 3'd3,
      CMD_EWDS  = 3'd4,
      CMD_ERAL  = 3'd5,
      CMD_WRAL  = 3'd6
   } sereep_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_RDATA,
      ST_GAP,
      ST_POLL,
      ST_FIN
   } sereep_st_e;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_ERASE = 2'b11;
   localparam logic [1:0] OP_EXT   = 2'b00;

   localparam logic [1:0] SUB_EN   = 2'b11;
   localparam logic [1:0] SUB_ERA  = 2'b10;
   localparam logic [1:0] SUB_WRA  = 2'b01;
   localparam logic [1:0] SUB_DIS  = 2'b00;
endpackage

// File: rtl/sereep_clkdiv.sv
`timescale 1ns/1ps
module sereep_clkdiv #(
   parameter int SK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (SK_HALF < 1) begin : g_bad_half
         $error("sereep_clkdiv: SK_HALF must be at least 1");
      end else if (SK_HALF == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(SK_HALF);
         localparam logic [CW-1:0] LAST = CW'(SK_HALF - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!en || cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = en && (cnt == LAST);

         // R2: half-period ticks never come back to back
         p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/sereep_framer.sv
`timescale 1ns/1ps
module sereep_framer
   import sereep_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int FW = 3 + ADDR_W + DATA_W,
   localparam int LW = $clog2(FW + 1)
) (
   input  logic [2:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [FW-1:0]     vec,
   output logic [LW-1:0]     len,
   output logic              is_read,
   output logic              is_prog
);
   localparam int PAD = ADDR_W - 2;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("sereep_framer: ADDR_W must be at least 3");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sereep_framer: DATA_W must be at least 2");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_EN  = {SUB_EN,  {PAD{1'b0}}};
   localparam logic [ADDR_W-1:0] A_ERA = {SUB_ERA, {PAD{1'b0}}};
   localparam logic [ADDR_W-1:0] A_WRA = {SUB_WRA, {PAD{1'b0}}};
   localparam logic [ADDR_W-1:0] A_DIS = {SUB_DIS, {PAD{1'b0}}};

   logic [1:0]        op;
   logic [ADDR_W-1:0] afield;
   logic              with_data;

   always_comb begin
      op        = OP_EXT;
      afield    = A_DIS;
      with_data = 1'b0;
      is_read   = 1'b0;
      is_prog   = 1'b0;
      case (sereep_cmd_e'(cmd))
         CMD_READ: begin
            op = OP_READ;  afield = addr; is_read = 1'b1;
         end
         CMD_WRITE: begin
            op = OP_WRITE; afield = addr; with_data = 1'b1; is_prog = 1'b1;
         end
         CMD_ERASE: begin
            op = OP_ERASE; afield = addr; is_prog = 1'b1;
         end
         CMD_EWEN: afield = A_EN;
         CMD_ERAL: begin
            afield = A_ERA; is_prog = 1'b1;
         end
         CMD_WRAL: begin
            afield = A_WRA; with_data = 1'b1; is_prog = 1'b1;
         end
         default: afield = A_DIS;
      endcase
      vec = {1'b1, op, afield, (with_data ? wdata : {DATA_W{1'b0}})};
      len = with_data ? LW'(FW) : LW'(3 + ADDR_W);
   end
endmodule

// File: rtl/sereep_status.sv
`timescale 1ns/1ps
module sereep_status #(
   parameter int GAP_CYC   = 50,
   parameter int MAX_POLLS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gap_en,
   input  logic poll_en,
   input  logic tick,
   input  logic ready_in,
   output logic gap_done,
   output logic poll_ok,
   output logic poll_to
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam int PW = $clog2(MAX_POLLS + 1);
   localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
   localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("sereep_status: GAP_CYC must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("sereep_status: MAX_POLLS must be at least 1");
      end
   endgenerate

   logic [GW-1:0] gap_cnt;
   logic [PW-1:0] poll_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_cnt <= '0;
      else if (!gap_en)
         gap_cnt <= '0;
      else if (gap_cnt != GAP_LAST)
         gap_cnt <= gap_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         poll_cnt <= '0;
      else if (!poll_en)
         poll_cnt <= '0;
      else if (tick && poll_cnt != POLL_LAST)
         poll_cnt <= poll_cnt + 1'b1;
   end

   assign gap_done = gap_en && (gap_cnt == GAP_LAST);
   assign poll_ok  = poll_en && tick && ready_in;
   assign poll_to  = poll_en && tick && !ready_in && (poll_cnt == POLL_LAST);

   // R5: the sample count never runs past the timeout limit
   p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      poll_en |-> (poll_cnt <= POLL_LAST));
   // R4: the low gap counter is idle outside the gap
   p_gap_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(gap_en) |-> (gap_cnt == '0));
endmodule

// File: rtl/sereep_host.sv
`timescale 1ns/1ps
module sereep_host
   import sereep_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int SK_HALF   = 4,
   parameter int GAP_CYC   = 50,
   parameter int MAX_POLLS = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              err,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   localparam int FW = 3 + ADDR_W + DATA_W;
   localparam int LW = $clog2(FW + 1);
   localparam int RW = $clog2(DATA_W + 2);

   sereep_st_e        st;
   logic [FW-1:0]     f_vec;
   logic [LW-1:0]     f_len;
   logic              f_read, f_prog;
   logic [FW-1:0]     shreg;
   logic [LW-1:0]     bits_left;
   logic              cur_read, cur_prog;
   logic [DATA_W-1:0] rd_sh;
   logic [RW-1:0]     rcnt;
   logic              err_q;
   logic              tick, div_en;
   logic              gap_done, poll_ok, poll_to;

   sereep_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
      .cmd     (req_cmd),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .vec     (f_vec),
      .len     (f_len),
      .is_read (f_read),
      .is_prog (f_prog)
   );

   assign div_en = (st == ST_SHIFT) || (st == ST_RDATA) || (st == ST_POLL);

   sereep_clkdiv #(.SK_HALF(SK_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (div_en),
      .tick  (tick)
   );

   sereep_status #(.GAP_CYC(GAP_CYC), .MAX_POLLS(MAX_POLLS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .gap_en   (st == ST_GAP),
      .poll_en  (st == ST_POLL),
      .tick     (tick),
      .ready_in (ee_do),
      .gap_done (gap_done),
      .poll_ok  (poll_ok),
      .poll_to  (poll_to)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ee_cs     <= 1'b0;
         ee_sk     <= 1'b0;
         ee_di     <= 1'b0;
         shreg     <= '0;
         bits_left <= '0;
         cur_read  <= 1'b0;
         cur_prog  <= 1'b0;
         rd_sh     <= '0;
         rcnt      <= '0;
         err_q     <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  shreg     <= f_vec << 1;
                  ee_di     <= f_vec[FW-1];
                  bits_left <= f_len;
                  cur_read  <= f_read;
                  cur_prog  <= f_prog;
                  err_q     <= 1'b0;
                  ee_cs     <= 1'b1;
                  ee_sk     <= 1'b0;
                  st        <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!ee_sk) begin
                     ee_sk     <= 1'b1;
                     bits_left <= bits_left - 1'b1;
                  end else begin
                     ee_sk <= 1'b0;
                     if (bits_left != '0) begin
                        ee_di <= shreg[FW-1];
                        shreg <= shreg << 1;
                     end else begin
                        ee_di <= 1'b0;
                        if (cur_read) begin
                           rcnt <= RW'(DATA_W + 1);
                           st   <= ST_RDATA;
                        end else if (cur_prog) begin
                           ee_cs <= 1'b0;
                           st    <= ST_GAP;
                        end else begin
                           ee_cs <= 1'b0;
                           st    <= ST_FIN;
                        end
                     end
                  end
               end
            end
            ST_RDATA: begin
               if (tick) begin
                  if (!ee_sk) begin
                     ee_sk <= 1'b1;
                     rd_sh <= {rd_sh[DATA_W-2:0], ee_do};
                     rcnt  <= rcnt - 1'b1;
                  end else begin
                     ee_sk <= 1'b0;
                     if (rcnt == '0) begin
                        ee_cs <= 1'b0;
                        st    <= ST_FIN;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (gap_done) begin
                  ee_cs <= 1'b1;
                  st    <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (poll_ok) begin
                  ee_cs <= 1'b0;
                  st    <= ST_FIN;
               end else if (poll_to) begin
                  ee_cs <= 1'b0;
                  err_q <= 1'b1;
                  st    <= ST_FIN;
               end
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign done      = (st == ST_FIN);
   assign rd_data   = (done && cur_read) ? rd_sh : '0;
   assign err       = done && err_q;

   // R2: data toward the device only moves while the serial clock is low
   p_di_sk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_cs && $past(ee_cs) && !$stable(ee_di)) |-> !ee_sk);
   // R9: no serial clock activity with the device deselected
   p_sk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sk);
   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: idle means deselected and not completing
   p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!ee_cs && !done));
   // R5: error only appears with completion
   p_err_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   // R4: chip select rises into polling only after the low gap
   p_gap_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ee_cs) && !req_ready && !$past(req_ready)) |-> !ee_sk);
endmodule

// File: tb/tb_sereep_host.sv
`timescale 1ns/1ps
module tb_sereep_host;
   localparam int SK_HALF   = 4;
   localparam int GAP_CYC   = 50;
   localparam int MAX_POLLS = 64;
   localparam int BUSY      = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_cmd = '0;
   logic [5:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done, err;
   logic [15:0] rd_data;
   logic        ee_cs, ee_sk, ee_di, ee_do;

   always #2.5 clk = ~clk;

   sereep_host #(.ADDR_W(6), .DATA_W(16), .SK_HALF(SK_HALF),
                 .GAP_CYC(GAP_CYC), .MAX_POLLS(MAX_POLLS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rd_data(rd_data), .err(err),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   // ---------------- device model ----------------
   logic [15:0] mem [64];
   logic [31:0] fr, last_fr;
   int          nbits, last_len, rk, busy_cnt, low_run, last_gap, cs_rises;
   int          rise_gap, gap_min, gap_max, di_viol;
   logic        reading, dout, wen, stuck, cs_q, sk_q, di_q;
   logic [5:0]  ra;

   assign ee_do = !ee_cs ? 1'b0 : reading ? dout : ((busy_cnt > 0) || stuck) ? 1'b0 : 1'b1;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      fr = '0; last_fr = '0; nbits = 0; last_len = 0; rk = 0; busy_cnt = 0;
      low_run = 0; last_gap = 0; cs_rises = 0; reading = 0; dout = 0; wen = 0;
      stuck = 0; cs_q = 0; sk_q = 0; di_q = 0; ra = '0;
      rise_gap = 0; gap_min = 1000; gap_max = 0; di_viol = 0;
   end

   always @(negedge clk) begin
      if (busy_cnt > 0) busy_cnt--;
      if (ee_cs && !cs_q) begin
         cs_rises++; last_gap = low_run; gap_min = 1000; gap_max = 0; rise_gap = 0;
      end
      if (!ee_cs) low_run++; else low_run = 0;
      if (ee_cs && cs_q && ee_sk && (ee_di != di_q)) di_viol++;
      if (ee_cs) rise_gap++;
      if (!ee_cs && cs_q && nbits > 0) begin last_fr = fr; last_len = nbits; end
      if (!ee_cs) begin
         nbits = 0; reading = 0; fr = '0;
      end else if (ee_sk && !sk_q) begin
         if (nbits > 0) begin
            if (rise_gap < gap_min) gap_min = rise_gap;
            if (rise_gap > gap_max) gap_max = rise_gap;
         end
         rise_gap = 0;
         if (reading) begin
            if (rk < 16) dout = mem[ra][15-rk];
            rk++;
         end else begin
            fr = {fr[30:0], ee_di};
            nbits++;
            if (nbits == 9 && fr[8]) begin
               case (fr[7:6])
                  2'b10: begin reading = 1; ra = fr[5:0]; rk = 0; dout = 0; end
                  2'b11: if (wen) begin mem[fr[5:0]] = 16'hFFFF; busy_cnt = BUSY; end
                  2'b00: begin
                     if (fr[5:4] == 2'b11) wen = 1;
                     else if (fr[5:4] == 2'b00) wen = 0;
                     else if (fr[5:4] == 2'b10 && wen) begin
                        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                        busy_cnt = BUSY;
                     end
                  end
                  default: ;
               endcase
            end
            if (nbits == 25 && fr[24] && wen) begin
               if (fr[23:22] == 2'b01) begin
                  mem[fr[21:16]] = fr[15:0]; busy_cnt = BUSY;
               end else if (fr[23:22] == 2'b00 && fr[21:20] == 2'b01) begin
                  for (int i = 0; i < 64; i++) mem[i] = fr[15:0];
                  busy_cnt = BUSY;
               end
            end
         end
      end
      cs_q = ee_cs; sk_q = ee_sk; di_q = ee_di;
   end

   // ---------------- checking ----------------
   int checks = 0;
   int errors = 0;
   int wd = 0;

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 150000) begin
         errors++; checks++;
         $display("FAIL R7 watchdog: actual=%0d expected<%0d", wd, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   logic [15:0] t_rd;
   logic        t_err;
   int          t_cyc, t_rises;
   logic        t_busy_seen, t_pulse_ok;

   task automatic run_cmd(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
      int base;
      base = cs_rises;
      @(negedge clk);
      req_cmd = c; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t_busy_seen = !req_ready;
      t_cyc = 1;
      while (!done && t_cyc < 20000) begin
         @(negedge clk);
         t_cyc++;
      end
      t_rd = rd_data; t_err = err;
      chk(!ee_cs, "R7 cs low at done", 32'(ee_cs), 0);
      @(negedge clk);
      t_pulse_ok = !done;
      t_rises = cs_rises - base;
   endtask

   task automatic t_reset();
      chk(!ee_cs && !ee_sk && !ee_di, "R8 pins idle", {ee_cs, ee_sk, ee_di}, 0);
      chk(req_ready && !done && !err, "R8 handshake idle", {req_ready, done, err}, 3'b100);
   endtask

   task automatic t_enable();
      run_cmd(3'd3, 6'd21, 16'hDEAD);
      chk(last_len == 9, "R1 enable length", last_len, 9);
      chk(last_fr[8:0] == 9'b1_00_110000, "R1 enable frame", last_fr[8:0], 9'b1_00_110000);
      chk(t_rises == 1, "R6 enable single select", t_rises, 1);
      chk(t_busy_seen, "R7 ready low while busy", 32'(t_busy_seen), 1);
      chk(t_pulse_ok, "R7 done one cycle", 32'(t_pulse_ok), 1);
   endtask

   task automatic t_write(input logic [5:0] a, input logic [15:0] d);
      run_cmd(3'd1, a, d);
      chk(last_len == 25, "R1 write length", last_len, 25);
      chk(last_fr[24:0] == {1'b1, 2'b01, a, d}, "R1 write frame", last_fr[24:0], {1'b1, 2'b01, a, d});
      chk(t_rises == 2, "R4 select reraised for poll", t_rises, 2);
      chk(last_gap == GAP_CYC, "R4 low gap length", last_gap, GAP_CYC);
      chk(!t_err, "R4 ready seen no error", 32'(t_err), 0);
      chk(busy_cnt == 0, "R4 done only after ready", busy_cnt, 0);
   endtask

   task automatic t_read(input logic [5:0] a, input logic [15:0] exp);
      run_cmd(3'd0, a, 16'h5555);
      chk(last_fr[8:0] == {1'b1, 2'b10, a} && last_len == 9, "R1 read frame", last_fr[8:0], {1'b1, 2'b10, a});
      chk(t_rd == exp, "R3 read data", t_rd, exp);
      chk(gap_min == 2*SK_HALF && gap_max == 2*SK_HALF, "R2 sk period", gap_max, 2*SK_HALF);
      chk(di_viol == 0, "R2 di moved while sk high", di_viol, 0);
   endtask

   task automatic t_erase();
      run_cmd(3'd2, 6'd5, 16'h0);
      chk(last_fr[8:0] == 9'b1_11_000101, "R1 erase frame", last_fr[8:0], 9'b1_11_000101);
      chk(t_rises == 2 && !t_err, "R4 erase polled", t_rises, 2);
      t_read(6'd5, 16'hFFFF);
   endtask

   task automatic t_write_all();
      run_cmd(3'd6, 6'd40, 16'h1234);
      chk(last_fr[24:0] == {1'b1, 2'b00, 6'b010000, 16'h1234}, "R1 write-all frame",
          last_fr[24:0], {1'b1, 2'b00, 6'b010000, 16'h1234});
      t_read(6'd0, 16'h1234);
      t_read(6'd63, 16'h1234);
   endtask

   task automatic t_erase_all();
      run_cmd(3'd5, 6'd9, 16'h0);
      chk(last_fr[8:0] == 9'b1_00_100000, "R1 erase-all frame", last_fr[8:0], 9'b1_00_100000);
      t_read(6'd17, 16'hFFFF);
   endtask

   task automatic t_disable();
      run_cmd(3'd4, 6'd63, 16'h0);
      chk(last_fr[8:0] == 9'b1_00_000000, "R1 disable frame", last_fr[8:0], 9'b1_00_000000);
      chk(t_rises == 1, "R6 disable no poll", t_rises, 1);
      t_write(6'd3, 16'h0000);
      t_read(6'd3, 16'hFFFF);
      run_cmd(3'd7, 6'd7, 16'h0);
      chk(last_fr[8:0] == 9'b1_00_000000, "R1 code 7 as disable", last_fr[8:0], 9'b1_00_000000);
   endtask

   task automatic t_timeout();
      stuck = 1'b1;
      run_cmd(3'd2, 6'd9, 16'h0);
      chk(t_err, "R5 timeout error", 32'(t_err), 1);
      chk(t_cyc >= MAX_POLLS*SK_HALF, "R5 timeout duration", t_cyc, MAX_POLLS*SK_HALF);
      stuck = 1'b0;
      repeat (BUSY + 4) @(negedge clk);
      run_cmd(3'd3, 6'd0, 16'h0);
      chk(!t_err, "R5 error cleared next request", 32'(t_err), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_enable();
      t_write(6'd5, 16'hA5C3);
      t_read(6'd5, 16'hA5C3);
      t_write(6'd63, 16'h8001);
      t_read(6'd63, 16'h8001);
      t_erase();
      t_write_all();
      t_erase_all();
      t_disable();
      run_cmd(3'd3, 6'd0, 16'h0);
      t_write(6'd42, 16'h6C39);
      t_read(6'd42, 16'h6C39);
      t_timeout();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule